// File: doc/BRIEF.md
# Packed Lane Left Shifter

This block shifts a 64-bit packed operand left by one unsigned count that all lanes share, and fills the vacated low bits with zeros. A lane is 16, 32 or 64 bits wide, so the operand holds four, two or one lanes. The lane width comes from an opcode byte. Lanes stay isolated: no bit shifted out of one lane enters its neighbour. If the count is larger than the top bit index of a lane, every lane of the result is zero.

The count has two possible sources. One is a full 64-bit operand, and all 64 of its bits are compared when the block decides whether the count is too large. The other is an 8-bit immediate. The opcode byte selects the source. Immediate-form opcodes also check the reg field of the operand-form byte. A request pulses `in_valid` for one cycle, and the result is registered with `out_valid` in the next cycle. An immediate-form request with a bad reg field, or an opcode the block does not recognise, raises `illegal_op` and leaves the result register as it was.

Top module: `psl_shift_unit`

## Requirements
- R1: Opcode 0xF1 (register count) and opcode 0x71 (immediate count) select four 16-bit lanes. Lane i occupies bits [16i+15:16i] and is shifted on its own.
- R2: Opcode 0xF2 and opcode 0x72 select two 32-bit lanes. Lane i occupies bits [32i+31:32i].
- R3: Opcode 0xF3 and opcode 0x73 treat all 64 bits as one lane.
- R4: The vacated low bits of every lane are zero, and bits shifted past the top of a lane are dropped.
- R5: A count above 15, 31 or 63 (for 16-, 32- or 64-bit lanes) makes the whole result zero. All 64 count bits are compared, so a set high bit forces zero even when the low bits are small.
- R6: Immediate forms take the count from `imm8`, unsigned 0..255, and ignore `cnt_in`. Register forms take the count from `cnt_in`.
- R7: An immediate form whose `form_byte[5:3]` is not 6, or any other opcode value, pulses `illegal_op` in the next cycle. In that cycle `out_valid` stays low and `result` keeps its previous value.
- R8: `result` and `out_valid` update on the clock edge that samples `in_valid`. Without `in_valid`, `out_valid` and `illegal_op` are low in the next cycle.
- R9: A synchronous active-high `rst` clears `out_valid`, `illegal_op` and `result`.
- R10: A count of zero passes `dst_in` through unchanged for every lane width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_byte | input | 8 | Opcode byte that selects lane width and count source |
| form_byte | input | 8 | Operand-form byte; bits [5:3] are checked on immediate forms |
| imm8 | input | 8 | Immediate count |
| dst_in | input | 64 | Packed operand to shift |
| cnt_in | input | 64 | Register count |
| out_valid | output | 1 | Result valid, one cycle after the request |
| illegal_op | output | 1 | Rejected request, one cycle after the request |
| result | output | 64 | Registered shifted operand |

## Verification
The hardest case to reach from the ports is an oversize count whose low bits look harmless. That needs a 64-bit register count with one bit set far above bit 5 and a small value in the low bits, and a truncating comparator would wrongly shift instead of producing zero. The stimulus aims such counts at every lane width. It also places counts exactly at and one above each lane's top index. Rejected immediate forms are issued right after a known nonzero result, so a result that changes when it should hold is visible at the port.

// File: rtl/psl_pkg.sv
package psl_pkg;
    localparam int DW     = 64;
    localparam int IMM_W  = 8;
    localparam int FIELD_REQ = 6;

    typedef enum logic [1:0] {
        LANE_16 = 2'd0,
        LANE_32 = 2'd1,
        LANE_64 = 2'd2
    } lane_sz_e;

    typedef struct packed {
        logic          out_valid;
        logic          illegal;
        logic [DW-1:0] result;
    } psl_state_t;
endpackage

// File: rtl/psl_decode.sv
module psl_decode
    import psl_pkg::*;
(
    input  logic [7:0] op_byte,
    input  logic [7:0] form_byte,
    output lane_sz_e   lane_sz,
    output logic       use_imm,
    output logic       legal
);
    logic field_ok;
    assign field_ok = (form_byte[5:3] == 3'(FIELD_REQ));

    always_comb begin
        lane_sz = LANE_64;
        use_imm = 1'b0;
        legal   = 1'b0;
        unique case (op_byte)
            8'hF1: begin lane_sz = LANE_16; legal = 1'b1; end
            8'hF2: begin lane_sz = LANE_32; legal = 1'b1; end
            8'hF3: begin lane_sz = LANE_64; legal = 1'b1; end
            8'h71: begin lane_sz = LANE_16; use_imm = 1'b1; legal = field_ok; end
            8'h72: begin lane_sz = LANE_32; use_imm = 1'b1; legal = field_ok; end
            8'h73: begin lane_sz = LANE_64; use_imm = 1'b1; legal = field_ok; end
            default: ;
        endcase
    end
endmodule

// File: rtl/psl_lane_shift.sv
module psl_lane_shift #(
    parameter int DW     = 64,
    parameter int LANE_W = 16
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] dst
);
    localparam int NLANE = DW / LANE_W;
    localparam int SH_W  = $clog2(LANE_W);

    logic oversize;
    assign oversize = |cnt[DW-1:SH_W];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        assign lane_in = src[g*LANE_W +: LANE_W];
        assign dst[g*LANE_W +: LANE_W] = oversize ? '0 : (lane_in << cnt[SH_W-1:0]);
    end
endmodule

// File: rtl/psl_shift_unit.sv
module psl_shift_unit
    import psl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    op_byte,
    input  logic [7:0]    form_byte,
    input  logic [7:0]    imm8,
    input  logic [63:0]   dst_in,
    input  logic [63:0]   cnt_in,
    output logic          out_valid,
    output logic          illegal_op,
    output logic [63:0]   result
);
    lane_sz_e      lane_sz;
    logic          use_imm;
    logic          legal;
    logic [DW-1:0] eff_cnt;
    logic [DW-1:0] sh16, sh32, sh64, shifted;
    psl_state_t    state_d, state_q;

    psl_decode u_dec (
        .op_byte  (op_byte),
        .form_byte(form_byte),
        .lane_sz  (lane_sz),
        .use_imm  (use_imm),
        .legal    (legal)
    );

    assign eff_cnt = use_imm ? {{(DW-IMM_W){1'b0}}, imm8} : cnt_in;

    psl_lane_shift #(.DW(DW), .LANE_W(16)) u_sh16 (.src(dst_in), .cnt(eff_cnt), .dst(sh16));
    psl_lane_shift #(.DW(DW), .LANE_W(32)) u_sh32 (.src(dst_in), .cnt(eff_cnt), .dst(sh32));
    psl_lane_shift #(.DW(DW), .LANE_W(64)) u_sh64 (.src(dst_in), .cnt(eff_cnt), .dst(sh64));

    always_comb begin
        unique case (lane_sz)
            LANE_16: shifted = sh16;
            LANE_32: shifted = sh32;
            default: shifted = sh64;
        endcase
    end

    always_comb begin
        state_d           = state_q;
        state_d.out_valid = 1'b0;
        state_d.illegal   = 1'b0;
        if (in_valid) begin
            if (legal) begin
                state_d.out_valid = 1'b1;
                state_d.result    = shifted;
            end else begin
                state_d.illegal   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign out_valid  = state_q.out_valid;
    assign illegal_op = state_q.illegal;
    assign result     = state_q.result;

    // Independent oversize view for checking: count beyond lane top index
    logic too_big;
    always_comb begin
        case (lane_sz)
            LANE_16: too_big = (eff_cnt > 64'd15);
            LANE_32: too_big = (eff_cnt > 64'd31);
            default: too_big = (eff_cnt > 64'd63);
        endcase
    end

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal |=> out_valid && !illegal_op);
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !illegal_op);
    p_hold_on_reject_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !legal |=> illegal_op && !out_valid && $stable(result));
    p_oversize_zero_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal && too_big |=> result == '0);
    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal && (eff_cnt == '0) |=> result == $past(dst_in));
    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && illegal_op));
endmodule

// File: tb/sim_psl_shift_unit.sv
module sim_psl_shift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  op_byte = '0, form_byte = '0, imm8 = '0;
    logic [63:0] dst_in = '0, cnt_in = '0;
    logic        out_valid, illegal_op;
    logic [63:0] result;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic        v;
        logic        ill;
        logic [63:0] res;
        string       tag;
    } exp_t;
    exp_t        sb[$];
    logic [63:0] last_res = '0;
    logic        mon_on = 1'b0;

    always #4 clk = ~clk;

    psl_shift_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_byte(op_byte),
        .form_byte(form_byte), .imm8(imm8), .dst_in(dst_in), .cnt_in(cnt_in),
        .out_valid(out_valid), .illegal_op(illegal_op), .result(result)
    );

    function automatic logic [63:0] ref_shift(input int w, input logic [63:0] d,
                                              input logic [63:0] c);
        logic [63:0] r = '0;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        if (c >= 64'(w)) return '0;
        for (int i = 0; i < 64 / w; i++) begin
            logic [63:0] lane = (d >> (i * w)) & mask;
            lane = (lane << c[5:0]) & mask;
            r = r | (lane << (i * w));
        end
        return r;
    endfunction

    task automatic issue(input logic [7:0] op, input logic [7:0] fb, input logic [7:0] im,
                         input logic [63:0] d, input logic [63:0] c, input string tag);
        exp_t e;
        int w = 0;
        logic ok = 1'b0;
        logic imm_form = 1'b0;
        case (op)
            8'hF1: begin w = 16; ok = 1'b1; end
            8'hF2: begin w = 32; ok = 1'b1; end
            8'hF3: begin w = 64; ok = 1'b1; end
            8'h71: begin w = 16; imm_form = 1'b1; ok = (fb[5:3] == 3'd6); end
            8'h72: begin w = 32; imm_form = 1'b1; ok = (fb[5:3] == 3'd6); end
            8'h73: begin w = 64; imm_form = 1'b1; ok = (fb[5:3] == 3'd6); end
            default: ok = 1'b0;
        endcase
        @(negedge clk);
        in_valid = 1'b1; op_byte = op; form_byte = fb; imm8 = im; dst_in = d; cnt_in = c;
        e.v = ok; e.ill = !ok; e.tag = tag;
        if (ok) last_res = ref_shift(w, d, imm_form ? {56'd0, im} : c);
        e.res = last_res;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; dst_in = 64'hDEAD_BEEF_0BAD_F00D; cnt_in = 64'd3;
        e.v = 1'b0; e.ill = 1'b0; e.res = last_res; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        if (mon_on && sb.size() > 0) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            tests++;
            if (out_valid !== e.v || illegal_op !== e.ill || result !== e.res) begin
                fails++;
                $display("FAIL %s: got v=%0b ill=%0b res=%h, expected v=%0b ill=%0b res=%h",
                         e.tag, out_valid, illegal_op, result, e.v, e.ill, e.res);
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || illegal_op !== 1'b0 || result !== 64'd0) begin
            fails++;
            $display("FAIL R9: got v=%0b ill=%0b res=%h, expected 0 0 0",
                     out_valid, illegal_op, result);
        end
        mon_on = 1'b1;
        // R1 word lanes, example values, register and immediate forms
        issue(8'hF1, 8'h00, 8'h00, 64'h11C7_FFFF_11C7_FFFF, 64'd2, "R1 word reg");
        issue(8'h71, 8'hF0, 8'd2, 64'hFFFF_11C7_8001_0001, 64'd0, "R1 word imm");
        issue(8'hF1, 8'h00, 8'h00, 64'h8000_8000_8000_8000, 64'd1, "R4 word carry dropped");
        // R2 dword
        issue(8'hF2, 8'h00, 8'h00, 64'h8000_0001_FFFF_0000, 64'd4, "R2 dword reg");
        issue(8'h72, 8'h30, 8'd17, 64'h1234_5678_9ABC_DEF0, 64'd0, "R2 dword imm");
        // R3 qword
        issue(8'hF3, 8'h00, 8'h00, 64'h0123_4567_89AB_CDEF, 64'd20, "R3 qword reg");
        issue(8'h73, 8'h37, 8'd63, 64'h0000_0000_0000_0003, 64'd0, "R3 qword imm 63");
        // R5 boundaries
        issue(8'hF1, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd15, "R5 word 15");
        issue(8'hF1, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, "R5 word 16");
        issue(8'hF2, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, "R5 dword 31");
        issue(8'hF2, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32, "R5 dword 32");
        issue(8'hF3, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, "R5 qword 64");
        issue(8'hF1, 8'h00, 8'h00, 64'h0001_0001_0001_0001, (64'd1 << 40) | 64'd2, "R5 word high bit");
        issue(8'hF2, 8'h00, 8'h00, 64'h0001_0001_0001_0001, (64'd1 << 63) | 64'd1, "R5 dword high bit");
        issue(8'hF3, 8'h00, 8'h00, 64'h0001_0001_0001_0001, (64'd1 << 6), "R5 qword bit6");
        issue(8'h71, 8'hF0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R5 imm 255");
        // R6 immediate ignores cnt_in
        issue(8'h71, 8'hF0, 8'd3, 64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_FFFF_FFFF, "R6 imm ignores cnt");
        issue(8'hF3, 8'hF0, 8'hFF, 64'h0000_0000_0000_0001, 64'd5, "R6 reg ignores imm");
        // R7 rejects hold result
        issue(8'h71, 8'hE8, 8'd1, 64'h1111_1111_1111_1111, 64'd0, "R7 bad field 5");
        issue(8'h73, 8'h00, 8'd1, 64'h1111_1111_1111_1111, 64'd0, "R7 bad field 0");
        issue(8'hF4, 8'h00, 8'd0, 64'h1111_1111_1111_1111, 64'd1, "R7 unknown op");
        // R8 idle and back-to-back
        idle("R8 idle");
        idle("R8 idle 2");
        // R10 zero count
        issue(8'hF1, 8'h00, 8'h00, 64'hA5A5_5A5A_C3C3_3C3C, 64'd0, "R10 word zero");
        issue(8'h72, 8'h30, 8'h00, 64'h8765_4321_0FED_CBA9, 64'd7, "R10 dword imm zero");
        issue(8'hF3, 8'h00, 8'h00, 64'hFEDC_BA98_7654_3210, 64'd0, "R10 qword zero");
        idle("R8 drain");
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule